// File: doc/BRIEF.md
# Self-timed USB host port resume controller

This block holds the resume control of one USB host port. Software starts resume signalling by writing 1 to the port's resume bit. The controller can also start it on its own when it sees the downstream device signal a wake-up: a J-to-K transition on the line while the port is suspended. For as long as the resume bit is 1, the block drives the K-state output enable. It counts the resume period against a 1 kHz strobe, then clears the bit without any help from software and reports that the port has returned to idle. Software cannot end resume early, because a write of 0 to the bit does nothing.

A wake-up started by the device also sets a port-change status bit, which software clears by writing 1 to it. When resume ends, the block samples the run/stop command bit. If run/stop is not yet set, the first start-of-frame cannot go out in time, so the block raises a flag warning that a high-speed device would fall back to full speed. While port power is off, the resume bit reads 0 and cannot be set.

Top module: `usb_port_resume_ctrl`

## Requirements
- R1: After reset, `resume_bit`, `resume_k_drive`, `port_change`, `idle_enter` and `sof_late` are all 0.
- R2: With `port_power`=1 and the resume bit clear, a cycle with `wr_resume_en`=1 and `wr_resume_val`=1 sets `resume_bit` at the next clock edge.
- R3: `line_k` passes through two synchronising flops and then a rising-edge detector. A rising `line_k` sets the resume bit on the third clock edge after the change, but only if `port_suspended`=1 in the cycle the edge is detected. Otherwise the edge is ignored.
- R4: `port_change` is set at the same edge at which a detected line edge sets the resume bit. A resume started by software leaves `port_change` unchanged.
- R5: `resume_k_drive` equals `resume_bit` in every cycle.
- R6: A write of 0 to the resume bit has no effect. Once set, the bit stays 1 until the timed period completes or port power drops. A repeated write of 1, or a repeated line edge, does not restart the count.
- R7: While the resume bit is 1, each cycle with `tick_1khz`=1 advances a counter that starts at 0 when the bit is set. At the edge where the counter reaches `RESUME_TICKS` (default 20), the bit is still 1. At the next edge the bit clears and `idle_enter` pulses high for exactly one cycle.
- R8: While `port_power`=0, `resume_bit` reads 0 in that same cycle, neither a write nor a line edge can set it, and a resume in progress is cancelled with no `idle_enter` pulse.
- R9: At the edge where a timed resume ends, `sof_late` is set if `run_stop` was 0 in the final cycle, and left clear otherwise. The flag holds until the next resume starts, which clears it.
- R10: `port_change` is write-1-to-clear through `wr_change_clr`. If a set event and a clear write fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1khz | input | 1 | One-cycle strobe once per millisecond |
| port_power | input | 1 | Port power is on |
| port_suspended | input | 1 | Port is in the suspend state |
| line_k | input | 1 | Asynchronous line-state K indication from the PHY |
| run_stop | input | 1 | Run/stop command bit |
| wr_resume_en | input | 1 | Software write strobe for the resume bit |
| wr_resume_val | input | 1 | Value written to the resume bit |
| wr_change_clr | input | 1 | Write-1-to-clear strobe for the port-change bit |
| resume_bit | output | 1 | Resume bit as read by software |
| resume_k_drive | output | 1 | Enable for driving K resume signalling |
| port_change | output | 1 | Port-change status bit |
| idle_enter | output | 1 | One-cycle pulse when timed resume ends and the port goes idle |
| sof_late | output | 1 | Run/stop was not set when resume ended |

## Verification
The assertions check the cycle-level invariants on every cycle:
- the counter never passes its limit;
- the line-edge detector never fires on two cycles in a row;
- the resume bit is held against zero writes and is cleared after power loss;
- an expired count always ends resume with an idle pulse;
- a late run/stop always raises the warning flag;
- a device-started resume always sets the change bit, even when a clear write arrives in the same cycle.

Only the bench scenarios can show the exact cycle counts at the port boundary:
- the three-edge synchroniser latency;
- the full 20-tick duration;
- that line edges are ignored outside suspend;
- that software starts leave the change bit alone;
- that the flag clears on the next start.

// File: rtl/usb_resume_pkg.sv
// Package: shared types for the port resume controller.
// Assumes: nothing beyond standard SystemVerilog.
package usb_resume_pkg;

    // Origin of a resume that starts in the current cycle
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_SW     = 2'd1,
        CAUSE_REMOTE = 2'd2
    } resume_cause_e;

    // Default number of 1 kHz ticks for which resume K is driven
    localparam int unsigned DEFAULT_RESUME_TICKS = 20;

endpackage

// File: rtl/prc_line_sync.sv
// Module: prc_line_sync
// Brings the asynchronous line-state K indication into the clock domain
// through a chain of STAGES flops, then emits a one-cycle pulse on its
// rising edge.
// Assumes: line_k is held for at least two clock cycles.
module prc_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_k,
    output logic k_rise
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    // First flop samples the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= line_k;
    end

    // Remaining synchroniser stages plus one history flop for edge detection
    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[gi] <= 1'b0;
            else        chain_q[gi] <= chain_q[gi-1];
        end
    end

    // Rising edge of the synchronised level
    always_comb k_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        k_rise |=> !k_rise); // R3

endmodule

// File: rtl/prc_resume_timer.sv
// Module: prc_resume_timer
// Counts 1 kHz strobes while resume is active and flags expiry once
// RESUME_TICKS strobes have been counted.
// Assumes: the count restarts at zero whenever active is low.
module prc_resume_timer #(
    parameter int unsigned RESUME_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = $clog2(RESUME_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RESUME_TICKS);

    logic [CW-1:0] cnt_q;

    // Advance on each strobe while active; saturate at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !active)               cnt_q <= '0;
        else if (tick && (cnt_q != LIMIT))   cnt_q <= cnt_q + 1'b1;
    end

    // Expiry is visible in the cycle after the final strobe edge
    always_comb expired = active && (cnt_q == LIMIT);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R7

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/prc_resume_state.sv
// Module: prc_resume_state
// Holds the resume bit, the port-change status bit, the idle pulse and the
// late start-of-frame warning. Decides when resume starts, ends or is
// cancelled.
// Assumes: k_rise is already synchronised; expired comes from the timer
// driven by resume_q.
module prc_resume_state
    import usb_resume_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_power,
    input  logic port_suspended,
    input  logic wr_resume_en,
    input  logic wr_resume_val,
    input  logic wr_change_clr,
    input  logic k_rise,
    input  logic expired,
    input  logic run_stop,
    output logic resume_q,
    output logic change_q,
    output logic idle_q,
    output logic late_q
);
    logic          sw_req;
    logic          hw_req;
    logic          start;
    logic          finish;
    resume_cause_e cause;

    // Classify start requests and detect timed completion
    always_comb begin
        sw_req = wr_resume_en & wr_resume_val;
        hw_req = k_rise & port_suspended;
        start  = port_power & ~resume_q & (sw_req | hw_req);
        finish = port_power & resume_q & expired;
        if (!start)      cause = CAUSE_NONE;
        else if (hw_req) cause = CAUSE_REMOTE;
        else             cause = CAUSE_SW;
    end

    // Resume bit: set by start, cleared by timer or loss of power only
    always_ff @(posedge clk) begin
        if (!rst_n || !port_power) resume_q <= 1'b0;
        else if (start)            resume_q <= 1'b1;
        else if (finish)           resume_q <= 1'b0;
    end

    // Port-change bit: set on device wake-up, W1C, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                    change_q <= 1'b0;
        else if (cause == CAUSE_REMOTE) change_q <= 1'b1;
        else if (wr_change_clr)        change_q <= 1'b0;
    end

    // One-cycle pulse when the port returns to idle after timed resume
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b0;
        else        idle_q <= finish;
    end

    // Warning that run/stop was not set in time for the first SOF
    always_ff @(posedge clk) begin
        if (!rst_n)                  late_q <= 1'b0;
        else if (start)              late_q <= 1'b0;
        else if (finish && !run_stop) late_q <= 1'b1;
    end

    AST_REMOTE_SETS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause == CAUSE_REMOTE) |=> (change_q && resume_q)); // R4

    AST_CHANGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req && start && wr_change_clr) |=> change_q); // R10

    AST_ZERO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_q && port_power && !expired) |=> resume_q); // R6

    AST_UNPOWERED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !port_power |=> (!resume_q && !idle_q)); // R8

    AST_EXPIRE_ENDS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!resume_q && idle_q)); // R7

    AST_LATE_SOF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !run_stop) |=> late_q); // R9

endmodule

// File: rtl/usb_port_resume_ctrl.sv
// Module: usb_port_resume_ctrl
// Top of the self-timed port resume controller: synchroniser, duration
// timer and bit state. Presents the resume bit gated by port power.
// Assumes: tick_1khz is a single-cycle strobe in the clk domain.
module usb_port_resume_ctrl #(
    parameter int unsigned RESUME_TICKS = usb_resume_pkg::DEFAULT_RESUME_TICKS,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1khz,
    input  logic port_power,
    input  logic port_suspended,
    input  logic line_k,
    input  logic run_stop,
    input  logic wr_resume_en,
    input  logic wr_resume_val,
    input  logic wr_change_clr,
    output logic resume_bit,
    output logic resume_k_drive,
    output logic port_change,
    output logic idle_enter,
    output logic sof_late
);
    logic k_rise;
    logic expired;
    logic resume_q;

    prc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_k (line_k),
        .k_rise (k_rise)
    );

    prc_resume_timer #(.RESUME_TICKS(RESUME_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (resume_q),
        .tick    (tick_1khz),
        .expired (expired)
    );

    prc_resume_state u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .port_power     (port_power),
        .port_suspended (port_suspended),
        .wr_resume_en   (wr_resume_en),
        .wr_resume_val  (wr_resume_val),
        .wr_change_clr  (wr_change_clr),
        .k_rise         (k_rise),
        .expired        (expired),
        .run_stop       (run_stop),
        .resume_q       (resume_q),
        .change_q       (port_change),
        .idle_q         (idle_enter),
        .late_q         (sof_late)
    );

    // Visible resume bit reads 0 immediately while unpowered
    always_comb begin
        resume_bit     = resume_q & port_power;
        resume_k_drive = resume_bit;
    end

    AST_UNPOWERED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !port_power |-> !resume_k_drive); // R8

endmodule

// File: tb/usb_port_resume_ctrl_bench.sv
`timescale 1ns/1ps
module usb_port_resume_ctrl_bench;
    localparam int unsigned TICKS = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1khz = 1'b0;
    logic port_power = 1'b0;
    logic port_suspended = 1'b0;
    logic line_k = 1'b0;
    logic run_stop = 1'b0;
    logic wr_resume_en = 1'b0;
    logic wr_resume_val = 1'b0;
    logic wr_change_clr = 1'b0;
    logic resume_bit, resume_k_drive, port_change, idle_enter, sof_late;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_port_resume_ctrl #(.RESUME_TICKS(TICKS)) u_usb_port_resume_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_1khz(tick_1khz),
        .port_power(port_power), .port_suspended(port_suspended),
        .line_k(line_k), .run_stop(run_stop),
        .wr_resume_en(wr_resume_en), .wr_resume_val(wr_resume_val),
        .wr_change_clr(wr_change_clr), .resume_bit(resume_bit),
        .resume_k_drive(resume_k_drive), .port_change(port_change),
        .idle_enter(idle_enter), .sof_late(sof_late)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic write_resume(input logic val);
        @(negedge clk); wr_resume_en = 1'b1; wr_resume_val = val;
        @(negedge clk); wr_resume_en = 1'b0; wr_resume_val = 1'b0;
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1khz = 1'b1;
            @(negedge clk); tick_1khz = 1'b0;
        end
    endtask

    // Runs the final tick, then checks the one-cycle-late clear and idle pulse
    task automatic finish_resume(input logic exp_late);
        pulse_ticks(TICKS);
        check("R7", "bit held at count limit", resume_bit, 1'b1);
        @(negedge clk);
        check("R7", "bit cleared after limit", resume_bit, 1'b0);
        check("R7", "idle pulse", idle_enter, 1'b1);
        check("R9", "late sof flag", sof_late, exp_late);
        @(negedge clk);
        check("R7", "idle pulse single cycle", idle_enter, 1'b0);
    endtask

    task automatic t_reset();
        check("R1", "resume bit", resume_bit, 1'b0);
        check("R1", "k drive", resume_k_drive, 1'b0);
        check("R1", "change bit", port_change, 1'b0);
        check("R1", "idle pulse", idle_enter, 1'b0);
        check("R1", "late flag", sof_late, 1'b0);
    endtask

    task automatic t_software_resume();
        port_power = 1'b1; port_suspended = 1'b1; run_stop = 1'b1;
        write_resume(1'b1);
        check("R2", "set by write", resume_bit, 1'b1);
        check("R5", "k drive follows bit", resume_k_drive, 1'b1);
        check("R4", "no change on sw start", port_change, 1'b0);
        pulse_ticks(5);
        write_resume(1'b0);
        check("R6", "zero write ignored", resume_bit, 1'b1);
        write_resume(1'b1);
        pulse_ticks(TICKS - 6);
        check("R6", "rewrite 1 no restart, still active", resume_bit, 1'b1);
        pulse_ticks(1);
        check("R6", "count not restarted: held at limit", resume_bit, 1'b1);
        @(negedge clk);
        check("R6", "count not restarted: cleared", resume_bit, 1'b0);
        check("R5", "k drive off", resume_k_drive, 1'b0);
        check("R9", "no late flag with run set", sof_late, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_remote_wake();
        run_stop = 1'b0;
        @(negedge clk); line_k = 1'b1;
        @(negedge clk);
        check("R3", "not set after 1 edge", resume_bit, 1'b0);
        @(negedge clk);
        check("R3", "not set after 2 edges", resume_bit, 1'b0);
        @(negedge clk);
        check("R3", "set after 3 edges", resume_bit, 1'b1);
        check("R4", "change set with hw start", port_change, 1'b1);
        finish_resume(1'b1);
        line_k = 1'b0;
    endtask

    task automatic t_not_suspended();
        @(negedge clk); port_suspended = 1'b0;
        repeat (3) @(negedge clk);
        line_k = 1'b1;
        repeat (5) @(negedge clk);
        check("R3", "edge ignored outside suspend", resume_bit, 1'b0);
        line_k = 1'b0; port_suspended = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_change_clear();
        @(negedge clk); wr_change_clr = 1'b1;
        @(negedge clk); wr_change_clr = 1'b0;
        check("R10", "w1c clears change", port_change, 1'b0);
        line_k = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_change_clr = 1'b1;
        @(negedge clk); wr_change_clr = 1'b0;
        check("R10", "set wins over clear", port_change, 1'b1);
        check("R9", "late flag cleared by new start", sof_late, 1'b0);
        run_stop = 1'b1;
        finish_resume(1'b0);
        line_k = 1'b0;
    endtask

    task automatic t_power();
        @(negedge clk); port_power = 1'b0;
        write_resume(1'b1);
        check("R8", "cannot set unpowered", resume_bit, 1'b0);
        @(negedge clk); port_power = 1'b1;
        @(negedge clk);
        check("R8", "no latent set after power up", resume_bit, 1'b0);
        write_resume(1'b1);
        check("R8", "set when powered", resume_bit, 1'b1);
        port_power = 1'b0;
        #0.5;
        check("R8", "reads 0 same cycle", resume_bit, 1'b0);
        check("R5", "drive 0 unpowered", resume_k_drive, 1'b0);
        @(negedge clk);
        check("R8", "no idle pulse on cancel", idle_enter, 1'b0);
        port_power = 1'b1;
        @(negedge clk);
        check("R8", "cancelled resume stays clear", resume_bit, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_software_resume();
        t_remote_wake();
        t_not_suspended();
        t_change_clear();
        t_power();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule